// File: doc/BRIEF.md
# Reloading Interval Timer

This block is a 32-bit up-counting interval timer for a control processor. Software loads a negative start value into the reload register and moves it into the live count. While running, the count advances on every pulse of a 1 MHz tick enable. When the count carries out of its top bit it takes the reload value again, and the block raises a completion flag. If a completion is already pending when another carry arrives, the block sets a sticky error flag instead. An interrupt request follows the enable bit at each carry.

The block has three registers on a plain single-cycle register bus. A write is applied in the clock cycle where `reg_wr` is high. Reads are combinational and have no side effects. The control register uses write-one-to-clear for its status flags. It also has two command bits that only act during a write. One copies the reload value into the count. The other advances a stopped count by one. Within a single control write the actions happen in a fixed order: status clear, then the enable and run update, then the copy, then the single step. The bus and the tick are plain control pins with no back-pressure. Every write is accepted in the cycle it is presented.

Register map (`reg_addr`): 0 is control, 1 is the live count (read only), 2 is the reload value, and 3 reads as zero. Control bits: 31 is the error flag, 7 is the completion flag, 6 is the interrupt enable, 5 is the single-step command, 4 is the copy command, and 0 is run.

Top module: `interval_reload_timer`

## Requirements
- R1: After reset the control, count and reload registers read zero and `irq` is low.
- R2: A read of address 0 returns the error flag in bit 31, the completion flag in bit 7, the enable in bit 6 and run in bit 0. All other bits, including the command bits 5 and 4, read as zero.
- R3: A control write with bit 4 set loads the count with the reload value in the next cycle.
- R4: While run is set, every `tick` pulse advances the count by one. A tick in the same cycle as a control write is dropped.
- R5: When the count carries out of bit 31 it loads the reload value. The completion flag is set, or, if that flag was already set, the error flag is set instead.
- R6: At a carry, `irq` becomes equal to the enable bit in force for that cycle.
- R7: A control write with bit 0 clear and bit 5 set adds one to the count. If this wraps to zero, the count loads the reload value and the flags and `irq` update as for a carry.
- R8: After any control write, `irq` is low unless both the completion flag and the enable are set.
- R9: Writing 1 to bit 31 or bit 7 clears that flag, and writing 0 leaves it. The error flag stays set until it is cleared this way or by reset.
- R10: Within one control write, the copy happens before the single step. With bits 4 and 5 set and bit 0 clear, the count becomes the reload value plus one. With bit 0 also set, no step occurs.
- R11: Writes to address 1 leave the count unchanged. Writes to address 2 set the reload value, which reads back at address 2.
- R12: While run is clear, `tick` pulses leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at the 1 MHz count rate |
| reg_wr | input | 1 | Write strobe, applied in this cycle |
| reg_addr | input | 2 | Register select (0 control, 1 count, 2 reload) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences separate the first carry (completion flag) from a second carry with the flag still pending (error flag). They also check carries with the enable on and off, so a design that ignores the enable shows up. Single steps are taken toward a wrap so the reload-on-wrap path is reached. Writes with both command bits set, with and without run, tell a correct action order apart from a swapped one. A tick placed on the same cycle as a control write exposes a design that lets the tick through. Random traffic then mixes ticks, reload writes near the wrap point, ignored count writes and control writes with random command and clear bits. It is compared against a bench model after every cycle.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_CNT  = 2'd1,
    A_NXT  = 2'd2,
    A_NONE = 2'd3
  } itmr_addr_e;

  // control bit positions that software decodes (error bit is the top bit)
  localparam int B_DONE = 7;
  localparam int B_IE   = 6;
  localparam int B_STEP = 5;
  localparam int B_XFER = 4;
  localparam int B_RUN  = 0;

endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_run,
  input  logic         xfer,
  input  logic         step,
  input  logic         nxt_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] nxt_q,
  output logic         ovf
);

  localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

  logic [W-1:0] base;
  logic [W:0]   sum;
  logic         inc_en;

  // the copy command feeds the incrementer so that copy-then-step is one add
  always_comb begin
    base   = xfer ? nxt_q : cnt_q;
    inc_en = tick_run | step;
    sum    = {1'b0, base} + ONE_X;
    ovf    = inc_en & sum[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      nxt_q <= '0;
    end else begin
      if (nxt_wr) nxt_q <= wdata;
      if (ovf)         cnt_q <= nxt_q;
      else if (inc_en) cnt_q <= sum[W-1:0];
      else if (xfer)   cnt_q <= nxt_q;
    end
  end

  p_tick_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_run && !xfer && (cnt_q != '1) |=> cnt_q == $past(cnt_q) + W'(1));

  p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_run && (cnt_q == '1) |=> cnt_q == $past(nxt_q));

  p_xfer_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !step |=> cnt_q == $past(nxt_q));

  p_copy_then_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && step && (nxt_q != '1) |=> cnt_q == $past(nxt_q) + W'(1));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_run && !step && !xfer |=> $stable(cnt_q));

  p_nxt_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_wr |=> nxt_q == $past(wdata));

endmodule

// File: rtl/itmr_status.sv
module itmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic clr_err,
  input  logic clr_done,
  input  logic w_ie,
  input  logic w_run,
  input  logic ovf,
  output logic err_q,
  output logic done_q,
  output logic ie_q,
  output logic run_q,
  output logic irq_q
);

  logic err_c, done_c, ie_n, run_n;
  logic err_n, done_n, irq_n;

  always_comb begin
    // stage 1: write-one-to-clear, stage 2: enable and run
    err_c  = ctl_wr ? (err_q & ~clr_err)   : err_q;
    done_c = ctl_wr ? (done_q & ~clr_done) : done_q;
    ie_n   = ctl_wr ? w_ie  : ie_q;
    run_n  = ctl_wr ? w_run : run_q;
    err_n  = err_c;
    done_n = done_c;
    irq_n  = irq_q;
    // carry from a tick or from a single step
    if (ovf) begin
      if (done_c) err_n  = 1'b1;
      else        done_n = 1'b1;
      irq_n = ie_n;
    end
    if (ctl_wr && !(done_n && ie_n)) irq_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      err_q  <= err_n;
      done_q <= done_n;
      ie_q   <= ie_n;
      run_q  <= run_n;
      irq_q  <= irq_n;
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(ctl_wr && clr_err) |=> err_q);

  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && clr_done && !ovf |=> !done_q);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !irq_q || (done_q && ie_q));

  p_second_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && done_q && !ctl_wr |=> err_q);

  p_first_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ctl_wr |=> done_q);

  p_irq_follows_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ctl_wr |=> irq_q == $past(ie_q));

endmodule

// File: rtl/itmr_rd_mux.sv
module itmr_rd_mux
  import itmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   addr,
  input  logic         err,
  input  logic         done,
  input  logic         ie,
  input  logic         run,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] rdata
);

  logic [W-1:0] ctl_view;

  always_comb begin
    ctl_view         = '0;
    ctl_view[W-1]    = err;
    ctl_view[B_DONE] = done;
    ctl_view[B_IE]   = ie;
    ctl_view[B_RUN]  = run;
    case (addr)
      A_CTL:   rdata = ctl_view;
      A_CNT:   rdata = cnt;
      A_NXT:   rdata = nxt;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/interval_reload_timer.sv
module interval_reload_timer
  import itmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq
);

  localparam int B_ERR = W - 1;

  logic ctl_wr, nxt_wr, tick_run, xfer, step, ovf;
  logic err_q, done_q, ie_q, run_q;
  logic [W-1:0] cnt_q, nxt_q;

  always_comb begin
    ctl_wr   = reg_wr && (reg_addr == A_CTL);
    nxt_wr   = reg_wr && (reg_addr == A_NXT);
    tick_run = tick && run_q && !ctl_wr;
    xfer     = ctl_wr && reg_wdata[B_XFER];
    step     = ctl_wr && !reg_wdata[B_RUN] && reg_wdata[B_STEP];
  end

  itmr_counter #(.W(W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_run (tick_run),
    .xfer     (xfer),
    .step     (step),
    .nxt_wr   (nxt_wr),
    .wdata    (reg_wdata),
    .cnt_q    (cnt_q),
    .nxt_q    (nxt_q),
    .ovf      (ovf)
  );

  itmr_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .clr_err  (reg_wdata[B_ERR]),
    .clr_done (reg_wdata[B_DONE]),
    .w_ie     (reg_wdata[B_IE]),
    .w_run    (reg_wdata[B_RUN]),
    .ovf      (ovf),
    .err_q    (err_q),
    .done_q   (done_q),
    .ie_q     (ie_q),
    .run_q    (run_q),
    .irq_q    (irq)
  );

  itmr_rd_mux #(.W(W)) u_rd_mux (
    .addr  (reg_addr),
    .err   (err_q),
    .done  (done_q),
    .ie    (ie_q),
    .run   (run_q),
    .cnt   (cnt_q),
    .nxt   (nxt_q),
    .rdata (reg_rdata)
  );

  p_cnt_readonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == A_CNT) && !(tick && run_q) |=> $stable(cnt_q));

  p_ctl_read_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_CTL |-> (reg_rdata[B_ERR-1:B_DONE+1] == '0) &&
                          (reg_rdata[B_STEP:B_RUN+1] == '0));

  p_tick_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ctl_wr && !reg_wdata[B_XFER] && !step |=> $stable(cnt_q));

endmodule

// File: tb/test_interval_reload_timer.sv
module test_interval_reload_timer;

  localparam int  W   = 32;
  localparam time CLK = 20ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd3;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench model state
  bit [31:0] m_cnt, m_nxt;
  bit        m_err, m_done, m_ie, m_run, m_irq;

  always #(CLK/2) clk = ~clk;

  interval_reload_timer #(.W(W)) i_interval_reload_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic bit [31:0] ctl_exp();
    return {m_err, 23'b0, m_done, m_ie, 5'b0, m_run};
  endfunction

  // expected state update, written from the requirements
  function automatic void model(input bit wr, input bit [1:0] a, input bit [31:0] d,
                                input bit tk);
    bit [32:0] s;
    bit        cw;
    bit [31:0] old_nxt;
    old_nxt = m_nxt;
    cw = wr && (a == 2'd0);
    if (cw) begin
      bit dn, er, ov;
      bit [31:0] c;
      er = m_err & ~d[31];
      dn = m_done & ~d[7];
      m_ie  = d[6];
      m_run = d[0];
      c = m_cnt;
      ov = 1'b0;
      if (d[4]) c = m_nxt;
      if (!d[0] && d[5]) begin
        s = {1'b0, c} + 33'd1;
        if (s[32]) begin ov = 1'b1; c = m_nxt; end
        else c = s[31:0];
      end
      if (ov) begin
        if (dn) er = 1'b1; else dn = 1'b1;
        m_irq = m_ie;
      end
      m_cnt = c; m_err = er; m_done = dn;
      if (!(m_done && m_ie)) m_irq = 1'b0;
    end else if (wr && a == 2'd2) begin
      m_nxt = d;
    end
    if (tk && m_run && !cw) begin
      s = {1'b0, m_cnt} + 33'd1;
      if (s[32]) begin
        m_cnt = old_nxt;
        if (m_done) m_err = 1'b1; else m_done = 1'b1;
        m_irq = m_ie;
      end else m_cnt = s[31:0];
    end
  endfunction

  // one clock: drive at negedge, update model at the edge, return at next negedge
  task automatic cyc(input bit wr, input bit [1:0] a, input bit [31:0] d, input bit tk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tick = tk;
    @(posedge clk);
    model(wr, a, d, tk);
    @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    rd(2'd0, v); chk(req, "control", v, ctl_exp());
    rd(2'd1, v); chk(req, "count",   v, m_cnt);
    rd(2'd2, v); chk(req, "reload",  v, m_nxt);
    chk(req, "irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    m_cnt = 0; m_nxt = 0; m_err = 0; m_done = 0; m_ie = 0; m_run = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1", "control", v, 32'h0);
    rd(2'd1, v); chk("R1", "count", v, 32'h0);
    rd(2'd2, v); chk("R1", "reload", v, 32'h0);
    chk("R1", "irq", {31'b0, irq}, 32'h0);

    // R11 reload is writable, count is not
    cyc(1, 2'd2, 32'hFFFF_FFFD, 0);
    rd(2'd2, v); chk("R11", "reload", v, 32'hFFFF_FFFD);
    cyc(1, 2'd1, 32'h0000_1234, 0);
    rd(2'd1, v); chk("R11", "count after write", v, 32'h0);

    // R3 copy, R2 command bits read as zero
    cyc(1, 2'd0, 32'h0000_0030 & 32'h10, 0);
    rd(2'd1, v); chk("R3", "count", v, 32'hFFFF_FFFD);
    rd(2'd0, v); chk("R2", "control", v, 32'h0);

    // R12 stopped count ignores ticks
    cyc(0, 2'd3, 0, 1);
    rd(2'd1, v); chk("R12", "count", v, 32'hFFFF_FFFD);

    // R4 counting
    cyc(1, 2'd0, 32'h0000_0041, 0);
    rd(2'd0, v); chk("R2", "control", v, 32'h0000_0041);
    cyc(0, 2'd3, 0, 1);
    cyc(0, 2'd3, 0, 1);
    rd(2'd1, v); chk("R4", "count", v, 32'hFFFF_FFFF);

    // R5 R6 first carry
    cyc(0, 2'd3, 0, 1);
    rd(2'd1, v); chk("R5", "count reload", v, 32'hFFFF_FFFD);
    rd(2'd0, v); chk("R5", "control", v, 32'h0000_00C1);
    chk("R6", "irq", {31'b0, irq}, 32'h1);

    // R5 second carry with completion pending
    repeat (3) cyc(0, 2'd3, 0, 1);
    rd(2'd0, v); chk("R5", "error set", v, 32'h8000_00C1);

    // R9 clear behaviour
    cyc(1, 2'd0, 32'h0000_0041, 0);
    rd(2'd0, v); chk("R9", "no clear", v, 32'h8000_00C1);
    cyc(1, 2'd0, 32'h8000_0041, 0);
    rd(2'd0, v); chk("R9", "error cleared", v, 32'h0000_00C1);
    chk("R8", "irq kept", {31'b0, irq}, 32'h1);

    // R8 irq drop when enable cleared
    cyc(1, 2'd0, 32'h0000_0001, 0);
    chk("R8", "irq dropped", {31'b0, irq}, 32'h0);
    cyc(1, 2'd0, 32'h0000_00C1, 0);
    rd(2'd0, v); chk("R9", "completion cleared", v, 32'h0000_0041);

    // R6 carry with enable off
    cyc(1, 2'd0, 32'h0000_0001, 0);
    repeat (3) cyc(0, 2'd3, 0, 1);
    rd(2'd0, v); chk("R6", "control", v, 32'h0000_0081);
    chk("R6", "irq low", {31'b0, irq}, 32'h0);

    // R7 single steps toward wrap
    cyc(1, 2'd0, 32'h0000_0080, 0);
    cyc(1, 2'd0, 32'h0000_0020, 0);
    rd(2'd1, v); chk("R7", "step", v, 32'hFFFF_FFFE);
    cyc(1, 2'd0, 32'h0000_0020, 0);
    cyc(1, 2'd0, 32'h0000_0020, 0);
    rd(2'd1, v); chk("R7", "wrap reload", v, 32'hFFFF_FFFD);
    rd(2'd0, v); chk("R7", "wrap flag", v, 32'h0000_0080);

    // R10 order within a write
    cyc(1, 2'd2, 32'h0000_0100, 0);
    cyc(1, 2'd0, 32'h0000_0030, 0);
    rd(2'd1, v); chk("R10", "copy then step", v, 32'h0000_0101);
    cyc(1, 2'd0, 32'h0000_0031, 0);
    rd(2'd1, v); chk("R10", "no step when running", v, 32'h0000_0100);

    // R4 tick dropped on a control write
    cyc(1, 2'd0, 32'h0000_0001, 1);
    rd(2'd1, v); chk("R4", "tick dropped", v, 32'h0000_0100);
    cyc(0, 2'd3, 0, 1);
    rd(2'd1, v); chk("R4", "tick counted", v, 32'h0000_0101);
    check_all("R2");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      bit [31:0] d;
      bit tk;
      op = $urandom_range(0, 99);
      tk = ($urandom_range(0, 3) != 0);
      if (op < 60) cyc(0, 2'd3, 0, tk);
      else if (op < 75) begin
        d = $urandom;
        d[0] = ($urandom_range(0, 3) != 0);
        cyc(1, 2'd0, d, tk);
      end else if (op < 88) begin
        d = 32'hFFFF_FFF0 | ($urandom & 32'hF);
        cyc(1, 2'd2, d, tk);
      end else if (op < 94) cyc(1, 2'd1, $urandom, tk);
      else cyc(1, 2'd3, $urandom, tk);
      check_all("R5");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule